// File: doc/BRIEF.md
# Dual-Source Power Path Selection Controller

This block is the digital controller of a power path that has two inputs and one output. It decides which of two supply inputs, called A and B, feeds the shared output. It drives one close-request signal for each input switch. Analog comparators and gate drivers sit outside the block, and their results arrive as flags: a valid flag per input (above undervoltage), an overvoltage flag per input, and a thermal-shutdown flag. All inputs are asynchronous, so each one passes through a two-stage synchronizer before the logic uses it.

The enable input sets who makes the choice. With enable high, a host controls the choice through a bidirectional selector pin, and the validity flags do not affect it. With enable low, the block picks the source itself from the valid flags and a default-preference pin. In that mode the selector pin becomes an output that reports which source is connected. An open-drain "other source available" output is pulled low whenever either input is invalid.

A change of source always opens the old switch first. The new switch closes only after a gap of a set number of cycles. The first closure after reset uses a short selection delay. Every closure after a switch has opened uses the long transition delay. Overvoltage and thermal flags force switches open with no delay. The rst_n input is expected to be already synchronized to clk.

Top module: `pwr_sel_ctrl`

## Requirements
- R1: With enable high, sel_pin_i = 1 selects input A and sel_pin_i = 0 selects input B. The preference pin and both valid flags have no effect on the choice.
- R2: With enable low and exactly one valid flag set, that input is selected, whatever the preference pin says.
- R3: With enable low and both inputs valid, pref_i = 0 selects A and pref_i = 1 selects B.
- R4: With enable low and neither input valid, both switch outputs are 0.
- R5: sel_pin_oe_o is 1 exactly while the synchronized enable is low. While it is driven, sel_pin_o is 1 when switch A is closed and 0 otherwise.
- R6: avail_pull_o is 0 when both inputs are valid and 1 when either input is invalid.
- R7: An overvoltage flag forces that input's switch open. When the flag clears, the switch closes again only after TRAN_DLY_CYC cycles with both switches open.
- R8: The thermal-shutdown flag forces both switches open.
- R9: sw_a_o and sw_b_o are never 1 in the same cycle.
- R10: The first closure after reset comes SEL_DLY_CYC cycles after the synchronized choice settles. A change of source opens the old switch and closes the new one after exactly TRAN_DLY_CYC cycles with both switches open.
- R11: A change on any input reaches the outputs on the third rising clock edge after it is sampled. This is two synchronizer stages plus one state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| en_i | input | 1 | Enable: 1 gives the choice to the host |
| sel_pin_i | input | 1 | Selector pin as read (1 = A, 0 = B) |
| pref_i | input | 1 | Default preference (0 = A, 1 = B) |
| valid_a_i | input | 1 | Input A above undervoltage |
| valid_b_i | input | 1 | Input B above undervoltage |
| ov_a_i | input | 1 | Input A overvoltage |
| ov_b_i | input | 1 | Input B overvoltage |
| tsd_i | input | 1 | Thermal shutdown |
| sw_a_o | output | 1 | Close switch A |
| sw_b_o | output | 1 | Close switch B |
| sel_pin_o | output | 1 | Status value on the selector pin |
| sel_pin_oe_o | output | 1 | Output enable of the selector pin |
| avail_pull_o | output | 1 | 1 = pull the availability line low |

## Verification
The bench times the switch-over edges cycle by cycle. A design with a short or missing gap, or with an off-by-one in its counter, closes the new switch early or late and is caught. Recovery from overvoltage is checked for the long delay: a design that resumes with the short selection delay closes too soon. Toggling the preference pin while enable is high catches a design that lets the automatic rule leak into host mode. Random mixes of valid, fault and mode inputs check the steady state against a bench model, and every cycle is checked so that the two switches are never closed together.

// File: rtl/pwr_sel_pkg.sv
package pwr_sel_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2
  } src_e;

  typedef enum logic {
    ST_GAP = 1'b0,
    ST_ON  = 1'b1
  } seq_st_e;

  localparam int NUM_SYNC_IN = 8;
endpackage

// File: rtl/pwr_sel_sync.sv
module pwr_sel_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwr_sel_pick.sv
module pwr_sel_pick
  import pwr_sel_pkg::*;
(
  input  logic en,
  input  logic sel,
  input  logic pref,
  input  logic va,
  input  logic vb,
  input  logic ova,
  input  logic ovb,
  input  logic tsd,
  output src_e target_o
);
  src_e choice;

  always_comb begin
    choice = SRC_NONE;
    if (en)            choice = sel ? SRC_A : SRC_B;
    else if (va && vb) choice = pref ? SRC_B : SRC_A;
    else if (va)       choice = SRC_A;
    else if (vb)       choice = SRC_B;

    target_o = choice;
    if (tsd)                           target_o = SRC_NONE;
    else if (choice == SRC_A && ova)   target_o = SRC_NONE;
    else if (choice == SRC_B && ovb)   target_o = SRC_NONE;
  end
endmodule

// File: rtl/pwr_sel_seq.sv
module pwr_sel_seq
  import pwr_sel_pkg::*;
#(
  parameter int SEL_DLY_CYC  = 1250,
  parameter int TRAN_DLY_CYC = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e target_i,
  output logic sw_a_o,
  output logic sw_b_o
);
  localparam int MAX_DLY = (SEL_DLY_CYC > TRAN_DLY_CYC) ? SEL_DLY_CYC : TRAN_DLY_CYC;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] SEL_LAST  = CNT_W'(SEL_DLY_CYC - 1);
  localparam logic [CNT_W-1:0] TRAN_LAST = CNT_W'(TRAN_DLY_CYC - 1);

  seq_st_e          state_q, state_d;
  src_e             cur_q, cur_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             long_q, long_d;
  logic             upd_en;
  logic [CNT_W-1:0] last;

  assign last = long_q ? TRAN_LAST : SEL_LAST;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    cnt_d   = cnt_q;
    long_d  = long_q;
    upd_en  = 1'b0;
    case (state_q)
      ST_ON: begin
        if (target_i != cur_q) begin
          upd_en  = 1'b1;
          state_d = ST_GAP;
          cur_d   = target_i;
          cnt_d   = '0;
          long_d  = 1'b1;
        end
      end
      default: begin
        if (target_i != cur_q) begin
          upd_en = 1'b1;
          cur_d  = target_i;
          cnt_d  = '0;
        end else if (cur_q != SRC_NONE) begin
          upd_en = 1'b1;
          if (cnt_q == last) begin
            state_d = ST_ON;
            long_d  = 1'b0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GAP;
      cur_q   <= SRC_NONE;
      cnt_q   <= '0;
      long_q  <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      cur_q   <= cur_d;
      cnt_q   <= cnt_d;
      long_q  <= long_d;
    end
  end

  assign sw_a_o = (state_q == ST_ON) && (cur_q == SRC_A);
  assign sw_b_o = (state_q == ST_ON) && (cur_q == SRC_B);
endmodule

// File: rtl/pwr_sel_ctrl.sv
module pwr_sel_ctrl
  import pwr_sel_pkg::*;
#(
  parameter int SEL_DLY_CYC  = 1250,
  parameter int TRAN_DLY_CYC = 2500000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic sel_pin_i,
  input  logic pref_i,
  input  logic valid_a_i,
  input  logic valid_b_i,
  input  logic ov_a_i,
  input  logic ov_b_i,
  input  logic tsd_i,
  output logic sw_a_o,
  output logic sw_b_o,
  output logic sel_pin_o,
  output logic sel_pin_oe_o,
  output logic avail_pull_o
);
  logic [NUM_SYNC_IN-1:0] raw, syn;
  src_e                   target;
  logic                   en_s, sel_s, pref_s, va_s, vb_s, ova_s, ovb_s, tsd_s;

  assign raw = {en_i, sel_pin_i, pref_i, valid_a_i, valid_b_i, ov_a_i, ov_b_i, tsd_i};

  pwr_sel_sync #(.WIDTH(NUM_SYNC_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
  );

  assign {en_s, sel_s, pref_s, va_s, vb_s, ova_s, ovb_s, tsd_s} = syn;

  pwr_sel_pick u_pick (
    .en(en_s), .sel(sel_s), .pref(pref_s), .va(va_s), .vb(vb_s),
    .ova(ova_s), .ovb(ovb_s), .tsd(tsd_s), .target_o(target)
  );

  pwr_sel_seq #(.SEL_DLY_CYC(SEL_DLY_CYC), .TRAN_DLY_CYC(TRAN_DLY_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .target_i(target), .sw_a_o(sw_a_o), .sw_b_o(sw_b_o)
  );

  assign sel_pin_oe_o = ~en_s;
  assign sel_pin_o    = sw_a_o;
  assign avail_pull_o = ~(va_s & vb_s);
endmodule

// File: rtl/pwr_sel_ctrl_chk.sv
module pwr_sel_ctrl_chk #(
  parameter int SEL_DLY_CYC = 1250
) (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic valid_a_i,
  input logic valid_b_i,
  input logic ov_a_i,
  input logic ov_b_i,
  input logic tsd_i,
  input logic sw_a_o,
  input logic sw_b_o,
  input logic sel_pin_oe_o,
  input logic avail_pull_o
);
  logic [31:0] off_run;
  logic [1:0]  since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run   <= '0;
      since_rst <= '0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      if (sw_a_o || sw_b_o)             off_run <= '0;
      else if (off_run != 32'hFFFF_FFFF) off_run <= off_run + 32'd1;
    end
  end

  p_mutex_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_a_o && sw_b_o));

  p_gap_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_a_o) |-> off_run >= 32'(SEL_DLY_CYC));

  p_gap_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_b_o) |-> off_run >= 32'(SEL_DLY_CYC));

  p_tsd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tsd_i, 3) |-> (!sw_a_o && !sw_b_o));

  p_ov_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ov_a_i, 3) |-> !sw_a_o);

  p_ov_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ov_b_i, 3) |-> !sw_b_o);

  p_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (sel_pin_oe_o == !$past(en_i, 2)));

  p_avail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (avail_pull_o == !($past(valid_a_i, 2) && $past(valid_b_i, 2))));
endmodule

bind pwr_sel_ctrl pwr_sel_ctrl_chk #(.SEL_DLY_CYC(SEL_DLY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .valid_a_i(valid_a_i), .valid_b_i(valid_b_i),
  .ov_a_i(ov_a_i), .ov_b_i(ov_b_i), .tsd_i(tsd_i), .sw_a_o(sw_a_o), .sw_b_o(sw_b_o),
  .sel_pin_oe_o(sel_pin_oe_o), .avail_pull_o(avail_pull_o)
);

// File: tb/pwr_sel_ctrl_test.sv
module pwr_sel_ctrl_test;
  localparam int SEL  = 4;
  localparam int TRAN = 12;
  localparam int SETTLE = 3 + TRAN + 3;

  logic clk;
  logic rst_n;
  logic en, sel, pref, va, vb, ova, ovb, tsd;
  logic sw_a, sw_b, spo, spoe, avl;
  int   errs;
  int   checks;
  bit   done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  pwr_sel_ctrl #(.SEL_DLY_CYC(SEL), .TRAN_DLY_CYC(TRAN)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .sel_pin_i(sel), .pref_i(pref),
    .valid_a_i(va), .valid_b_i(vb), .ov_a_i(ova), .ov_b_i(ovb), .tsd_i(tsd),
    .sw_a_o(sw_a), .sw_b_o(sw_b), .sel_pin_o(spo), .sel_pin_oe_o(spoe),
    .avail_pull_o(avl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_src(input bit e, s, p, a, b, oa, ob, t);
    int c;
    c = 0;
    if (e)           c = s ? 1 : 2;
    else if (a && b) c = p ? 2 : 1;
    else if (a)      c = 1;
    else if (b)      c = 2;
    if (t) c = 0;
    else if (c == 1 && oa) c = 0;
    else if (c == 2 && ob) c = 0;
    return c;
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_steady(input string req);
    int e;
    e = exp_src(en, sel, pref, va, vb, ova, ovb, tsd);
    chk(sw_a == (e == 1), req, int'(sw_a), int'(e == 1));
    chk(sw_b == (e == 2), req, int'(sw_b), int'(e == 2));
    chk(spoe == !en, "R5 oe", int'(spoe), int'(!en));
    if (!en) chk(spo == (e == 1), "R5 status", int'(spo), int'(e == 1));
    chk(avl == !(va && vb), "R6 avail", int'(avl), int'(!(va && vb)));
  endtask

  // R9: mutual exclusion watched on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) chk(!(sw_a && sw_b), "R9 mutex", int'(sw_a && sw_b), 0);
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    errs = 0; checks = 0; done = 1'b0;
    rst_n = 1'b0;
    en = 0; sel = 0; pref = 1; va = 1; vb = 0; ova = 0; ovb = 0; tsd = 0;
    wait_n(3);
    chk(!sw_a && !sw_b, "reset sw", int'({sw_a, sw_b}), 0);
    chk(spoe == 1'b1, "reset oe R5", int'(spoe), 1);
    chk(avl == 1'b1, "reset avail R6", int'(avl), 1);
    rst_n = 1'b1;
    // R10/R2: first closure after SEL cycles, only A valid
    wait_n(2 + SEL);
    chk(sw_a == 1'b0, "R10 early close", int'(sw_a), 0);
    wait_n(1);
    chk(sw_a == 1'b1, "R10 R2 first close", int'(sw_a), 1);
    check_steady("R2 only A");

    // R3/R10/R11: B becomes valid, pref=1 -> B with break-before-make
    vb = 1;
    wait_n(2);
    chk(sw_a == 1'b1, "R11 latency", int'(sw_a), 1);
    wait_n(1);
    chk(sw_a == 1'b0, "R11 open", int'(sw_a), 0);
    wait_n(TRAN - 1);
    chk(sw_b == 1'b0, "R10 gap", int'(sw_b), 0);
    wait_n(1);
    chk(sw_b == 1'b1, "R10 R3 close B", int'(sw_b), 1);
    check_steady("R3 pref1");

    pref = 0; wait_n(SETTLE); check_steady("R3 pref0");

    // R1: host mode, preference toggling has no effect
    en = 1; sel = 1; wait_n(SETTLE); check_steady("R1 sel1");
    for (int i = 0; i < 20; i++) begin
      pref = ~pref; va = i[0]; vb = i[1];
      wait_n(1);
      chk(sw_a == 1'b1, "R1 pref ignored", int'(sw_a), 1);
    end
    va = 0; vb = 0; sel = 0; wait_n(SETTLE); check_steady("R1 sel0 invalid");

    // R4
    en = 0; wait_n(SETTLE); check_steady("R4 none");

    // R7: overvoltage on A, then recovery with the long gap
    va = 1; wait_n(SETTLE); check_steady("R2 A again");
    ova = 1; wait_n(3);
    chk(sw_a == 1'b0, "R7 ov open", int'(sw_a), 0);
    wait_n(SETTLE); check_steady("R7 ov held");
    ova = 0;
    wait_n(2 + TRAN);
    chk(sw_a == 1'b0, "R7 recovery gap", int'(sw_a), 0);
    wait_n(1);
    chk(sw_a == 1'b1, "R7 recovery close", int'(sw_a), 1);

    // R8
    vb = 1; en = 1; sel = 0; wait_n(SETTLE); check_steady("R1 B");
    tsd = 1; wait_n(3);
    chk(!sw_a && !sw_b, "R8 tsd", int'({sw_a, sw_b}), 0);
    wait_n(SETTLE); check_steady("R8 tsd held");
    tsd = 0; wait_n(SETTLE); check_steady("R8 release");

    // random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 60; k++) begin
      en   = 1'($urandom);
      sel  = 1'($urandom);
      pref = 1'($urandom);
      va   = 1'($urandom);
      vb   = 1'($urandom);
      ova  = ($urandom % 6) == 0;
      ovb  = ($urandom % 6) == 0;
      tsd  = ($urandom % 8) == 0;
      wait_n(SETTLE);
      check_steady(en ? "R1 R7 R8 rand" : "R2 R3 R4 R7 R8 rand");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule